// File: doc/BRIEF.md
# Host Serial Slave with Mode-Code Handshake

This block is the serial slave a host controller talks to over a three-wire synchronous link plus an enable line and a busy line. The host raises the enable, then clocks in a first byte that holds a six-bit code and a direction flag. The slave compares the code with a value supplied by the surrounding logic. On a match it pulls its data output low as an acknowledge. On a mismatch the output stays high and the rest of the frame has no effect.

After an acknowledge, the direction flag selects what the rest of the frame does. With the flag low, every later byte is a command: it is handed to the internal logic, and the busy line is held low until that logic takes the byte. With the flag high, the slave shifts bytes fetched from the internal logic out to the host. All serial inputs are brought into the system clock domain through synchronizers. Input bits are taken on detected rising serial-clock edges, and the data output moves only on detected falling edges.

Top module: `host_serial_slave`

## Requirements
- R1: While reset is held, sdo is 1, busy_n is 1, cmd_valid is 0, rd_pop is 0 and sdo_oe is 0.
- R2: The first byte of a frame is taken MSB first. Bits 7..2 are the code, bit 1 is the direction, and bit 0 is ignored. If bits 7..2 equal match_code, sdo is 0 after the eighth falling edge of that byte. During the seven falling edges before it, sdo is 1.
- R3: If bits 7..2 differ from match_code, sdo stays 1 until enable drops. The later bytes of that frame never raise cmd_valid or rd_pop.
- R4: With direction 0 and a match, every later group of eight bits (MSB first) appears on cmd_byte with cmd_valid at 1 and busy_n at 0. sdo stays 0 for the rest of the frame.
- R5: cmd_valid and cmd_byte hold until cmd_ack is seen. Serial bits clocked in while cmd_valid is 1 are discarded.
- R6: With direction 1 and a match, rd_data is captured at the acknowledge falling edge and again at the eighth falling edge of each data byte, and rd_pop pulses once for each capture. Falling edge n (1..8) of a data byte shows bit 8-n of the captured byte.
- R7: Dropping the enable partway through any byte discards the partial bits. The next frame starts again with a mode-code byte.
- R8: With cfg_tristate 1, sdo_oe is 1 only while the synchronized enable is high. With cfg_tristate 0, sdo_oe is 1 at all times outside reset.
- R9: sdo changes only after a detected falling serial-clock edge or while enable is low. It never changes during the high phase of the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| cs | input | 1 | Active-high frame enable |
| cfg_tristate | input | 1 | 1 selects 3-state output drive, 0 selects push-pull |
| match_code | input | CODE_W | Code compared against bits 7..2 of the mode byte |
| sdo | output | 1 | Serial data / ACK level to host |
| sdo_oe | output | 1 | Output-enable for the sdo pad |
| busy_n | output | 1 | Active-low busy, low while a command byte is pending |
| cmd_byte | output | BYTE_W | Last received command byte |
| cmd_valid | output | 1 | Command byte pending |
| cmd_ack | input | 1 | Internal logic consumes the pending command |
| rd_data | input | BYTE_W | Byte to return to the host |
| rd_pop | output | 1 | One-cycle pulse when rd_data is captured |

## Verification
Two events can land on the same clock cycle: a command byte completing on a rising serial edge, and a consumer acknowledge clearing the previous byte. Bits clocked while busy is low must be lost, and a byte sent after the acknowledge must be kept. The bench sends a byte while busy, checks that the held byte is unchanged, then acknowledges and sends another byte that must replace it. A second overlap arises in read frames, where the acknowledge level and the first capture of rd_data share one falling edge. That is judged by the ACK bit seen on the mode byte together with the exact data byte shifted out next.

// File: rtl/host_serial_slave.sv
module host_serial_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = 6,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              cs,
  input  logic              cfg_tristate,
  input  logic [CODE_W-1:0] match_code,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy_n,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_valid,
  input  logic              cmd_ack,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_pop
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int DIR_BIT = BYTE_W - CODE_W - 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_MODE, S_WRITE, S_READ, S_IGN} st_t;

  logic [SYNC_STAGES-1:0] sck_sy, sdi_sy, cs_sy;
  logic sck_s, sdi_s, cs_s, sck_d, sck_rise, sck_fall;
  st_t st;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] nxt, tx;
  logic rd_first, sdo_q, oe_q;

  assign sck_s    = sck_sy[SYNC_STAGES-1];
  assign sdi_s    = sdi_sy[SYNC_STAGES-1];
  assign cs_s     = cs_sy[SYNC_STAGES-1];
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign nxt      = {shreg, sdi_s};
  assign sdo      = sdo_q;
  assign sdo_oe   = oe_q;
  assign busy_n   = ~cmd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sy <= '0;
      sdi_sy <= '0;
      cs_sy  <= '0;
    end else begin
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck};
      sdi_sy <= {sdi_sy[SYNC_STAGES-2:0], sdi};
      cs_sy  <= {cs_sy[SYNC_STAGES-2:0], cs};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d     <= 1'b0;
      st        <= S_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      tx        <= '0;
      rd_first  <= 1'b0;
      sdo_q     <= 1'b1;
      oe_q      <= 1'b0;
      cmd_byte  <= '0;
      cmd_valid <= 1'b0;
      rd_pop    <= 1'b0;
    end else begin
      sck_d  <= sck_s;
      rd_pop <= 1'b0;
      oe_q   <= ~cfg_tristate | cs_s;
      if (cmd_valid && cmd_ack) cmd_valid <= 1'b0;
      if (!cs_s) begin
        st       <= S_IDLE;
        cnt      <= '0;
        sdo_q    <= 1'b1;
        rd_first <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            st  <= S_MODE;
            cnt <= '0;
          end
          S_MODE: begin
            if (sck_rise) begin
              shreg <= nxt[BYTE_W-2:0];
              cnt   <= cnt + 1'b1;
              if (cnt == LAST) begin
                cnt <= '0;
                if (nxt[BYTE_W-1 -: CODE_W] == match_code) begin
                  st       <= nxt[DIR_BIT] ? S_READ : S_WRITE;
                  rd_first <= nxt[DIR_BIT];
                end else begin
                  st <= S_IGN;
                end
              end
            end else if (sck_fall) begin
              sdo_q <= 1'b1;
            end
          end
          S_WRITE: begin
            if (sck_rise && !cmd_valid) begin
              shreg <= nxt[BYTE_W-2:0];
              cnt   <= cnt + 1'b1;
              if (cnt == LAST) begin
                cnt       <= '0;
                cmd_byte  <= nxt;
                cmd_valid <= 1'b1;
              end
            end else if (sck_fall) begin
              sdo_q <= 1'b0;
            end
          end
          S_READ: begin
            if (sck_fall) begin
              if (rd_first) begin
                sdo_q    <= 1'b0;
                tx       <= rd_data;
                rd_pop   <= 1'b1;
                rd_first <= 1'b0;
                cnt      <= '0;
              end else begin
                sdo_q <= tx[BYTE_W-1];
                tx    <= tx << 1;
                if (cnt == LAST) begin
                  cnt    <= '0;
                  tx     <= rd_data;
                  rd_pop <= 1'b1;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
            end
          end
          default: begin
            if (sck_fall) sdo_q <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/host_serial_slave_chk.sv
module host_serial_slave_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck_fall,
  input logic              cs_s,
  input logic              cfg_tristate,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              cmd_valid,
  input logic              cmd_ack,
  input logic [BYTE_W-1:0] cmd_byte,
  input logic              rd_pop,
  input logic              in_ign
);
  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_byte));

  a_r8_tristate_off: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_tristate && !cs_s |=> !sdo_oe);

  a_r9_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sck_fall) || !$past(cs_s));

  a_r3_nack_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ign |-> sdo);

  a_r6_pop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> $past(sck_fall));
endmodule

bind host_serial_slave host_serial_slave_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .cs_s(cs_s),
  .cfg_tristate(cfg_tristate), .sdo(sdo), .sdo_oe(sdo_oe),
  .cmd_valid(cmd_valid), .cmd_ack(cmd_ack), .cmd_byte(cmd_byte),
  .rd_pop(rd_pop), .in_ign(st == S_IGN)
);

// File: tb/test_host_serial_slave.sv
`timescale 1ns/1ps
module test_host_serial_slave;
  localparam int HP = 6;
  localparam int NV = 8;
  localparam logic [5:0] CODE = 6'h2D;
  // {mode byte, data byte, expected match}
  localparam logic [16:0] VEC [NV] = '{
    {8'hB4, 8'h5A, 1'b1}, {8'hB5, 8'hC3, 1'b1}, {8'hB6, 8'h00, 1'b1},
    {8'hB0, 8'h77, 1'b0}, {8'hFE, 8'h00, 1'b0}, {8'h34, 8'h99, 1'b0},
    {8'hB7, 8'h00, 1'b1}, {8'hB4, 8'h81, 1'b1}};

  logic clk = 0, rst_n = 0, sck = 0, sdi = 0, cs = 0, cfg_tristate = 0, cmd_ack = 0;
  logic sdo, sdo_oe, busy_n, cmd_valid, rd_pop;
  logic [7:0] cmd_byte, rd_data, pc = 0;
  int tests = 0, fails = 0, r9_viol = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always_ff @(posedge clk) if (rd_pop) pc <= pc + 8'd1;
  assign rd_data = 8'hA0 + pc;

  host_serial_slave i_host_serial_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs(cs),
    .cfg_tristate(cfg_tristate), .match_code(CODE), .sdo(sdo), .sdo_oe(sdo_oe),
    .busy_n(busy_n), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid), .cmd_ack(cmd_ack),
    .rd_data(rd_data), .rd_pop(rd_pop));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, output logic [7:0] rx);
    logic pre;
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = b[i];
      wt(HP);
      pre = sdo;
      sck = 1;
      wt(HP);
      if (sdo !== pre) r9_viol++;
      sck = 0;
      wt(HP);
      rx[i] = sdo;
    end
  endtask

  task automatic frame_on;
    cs = 1;
    wt(HP);
  endtask

  task automatic frame_off;
    cs = 0;
    wt(HP);
  endtask

  task automatic ack_cmd;
    cmd_ack = 1;
    wt(1);
    cmd_ack = 0;
    wt(1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 60000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] rx, rx2, pc0;
    wt(4);
    // R1 reset values
    chk(sdo === 1'b1 && busy_n === 1'b1 && cmd_valid === 1'b0 && rd_pop === 1'b0 && sdo_oe === 1'b0,
        "R1 reset outputs", {sdo, busy_n, cmd_valid, rd_pop, sdo_oe}, 5'b11000);
    rst_n = 1;
    wt(4);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] mb, db;
      logic em;
      {mb, db, em} = VEC[v];
      pc0 = pc;
      frame_on();
      send_bits(mb, 8, rx);
      chk(rx === (em ? 8'hFE : 8'hFF), em ? "R2 ack on match" : "R3 nack on mismatch", rx, em ? 8'hFE : 8'hFF);
      send_bits(db, 8, rx2);
      if (!em) begin
        chk(rx2 === 8'hFF && cmd_valid === 1'b0 && pc === pc0, "R3 frame ignored",
            {rx2, cmd_valid, pc}, {8'hFF, 1'b0, pc0});
      end else if (!mb[1]) begin
        chk(cmd_valid === 1'b1 && busy_n === 1'b0 && cmd_byte === db, "R4 command byte",
            {cmd_valid, busy_n, cmd_byte}, {1'b1, 1'b0, db});
        chk(rx2 === 8'h00, "R4 ack held", rx2, 8'h00);
      end else begin
        chk(rx2 === 8'hA0 + pc0, "R6 read byte", rx2, 8'hA0 + pc0);
        chk(pc === pc0 + 8'd2, "R6 pop count", pc, pc0 + 8'd2);
      end
      frame_off();
      if (cmd_valid) ack_cmd();
      chk(busy_n === 1'b1, "R5 busy released", busy_n, 1'b1);
    end

    // R5 bits clocked while busy are discarded
    frame_on();
    send_bits(8'hB4, 8, rx);
    send_bits(8'h11, 8, rx);
    send_bits(8'h22, 8, rx);
    chk(cmd_byte === 8'h11 && cmd_valid === 1'b1, "R5 hold while busy", cmd_byte, 8'h11);
    ack_cmd();
    chk(busy_n === 1'b1, "R5 release on ack", busy_n, 1'b1);
    send_bits(8'h33, 8, rx);
    chk(cmd_byte === 8'h33 && cmd_valid === 1'b1, "R5 next byte after ack", cmd_byte, 8'h33);
    ack_cmd();
    frame_off();

    // R7 partial data byte discarded
    frame_on();
    send_bits(8'hB4, 8, rx);
    send_bits(8'hF0, 4, rx);
    frame_off();
    chk(cmd_valid === 1'b0, "R7 partial byte dropped", cmd_valid, 1'b0);
    frame_on();
    send_bits(8'hB4, 8, rx);
    chk(rx[0] === 1'b0, "R7 new mode byte acked", rx[0], 1'b0);
    send_bits(8'h3C, 8, rx);
    chk(cmd_byte === 8'h3C, "R7 fresh byte after abort", cmd_byte, 8'h3C);
    ack_cmd();
    frame_off();

    // R7 partial mode byte discarded, then read frame
    frame_on();
    send_bits(8'hE0, 3, rx);
    frame_off();
    pc0 = pc;
    frame_on();
    send_bits(8'hB6, 8, rx);
    chk(rx === 8'hFE, "R7 mode byte after abort", rx, 8'hFE);
    send_bits(8'h00, 8, rx);
    send_bits(8'h00, 8, rx2);
    chk(rx === 8'hA0 + pc0 && rx2 === 8'hA1 + pc0, "R6 two read bytes", {rx, rx2}, {8'hA0 + pc0, 8'hA1 + pc0});
    frame_off();

    // R8 output enable
    cfg_tristate = 1;
    wt(HP);
    chk(sdo_oe === 1'b0, "R8 off without enable", sdo_oe, 1'b0);
    frame_on();
    chk(sdo_oe === 1'b1, "R8 on with enable", sdo_oe, 1'b1);
    frame_off();
    chk(sdo_oe === 1'b0, "R8 off after enable", sdo_oe, 1'b0);
    cfg_tristate = 0;
    wt(HP);
    chk(sdo_oe === 1'b1, "R8 push-pull always on", sdo_oe, 1'b1);

    chk(r9_viol == 0, "R9 sdo stable in high phase", r9_viol, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule